// File: doc/BRIEF.md
# SDRAM Start-Up Sequencer

This block brings a single-data-rate SDRAM from power-on to an operational state. Once reset is released it holds clock-enable low and keeps the chip deselected. Partway through a programmable power-up wait it raises clock-enable and sends NOPs. When the wait ends it precharges every bank. It then runs a configurable number of auto-refresh commands. Last, it writes the mode register with a word built from separate configuration fields.

Every wait is a parameter counted in clock cycles. Each command takes one cycle, and the next command follows after exactly the parameterised gap, with NOPs in between. The `init_done` flag goes high when the mode-register wait ends. From then on the block drives NOP until the next reset. A refresh count below two is raised to two.

All outputs come from registers. The pins show the command chosen for cycle k at the clock edge that ends cycle k. Counting from the first rising edge after reset is released (edge 0), power-up cycle k appears at the pins after edge k.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is high, and at the first edge after it is released, `sd_cke` is 0, `sd_cs_n` is 1 (command inhibit, `{cs_n,ras_n,cas_n,we_n}` = 1111) and `init_done` is 0.
- R2: During power-up cycles 0 to CKE_RISE_CYC-1, `sd_cke` is 0 with inhibit. From cycle CKE_RISE_CYC to PWRUP_CYC-1, `sd_cke` is 1 with NOP (0111). After that, `sd_cke` stays 1.
- R3: The first command after the power-up wait is precharge (0010) with address bit 10 set to 1. It is issued at cycle PWRUP_CYC.
- R4: After each command, only NOP is driven until the next command. The gap is exactly TRP_CYC after precharge, TRFC_CYC after each refresh and TMRD_CYC after the mode load. No other commands appear.
- R5: max(2, REF_LOOPS) auto-refresh commands (0001) follow the precharge. The first comes TRP_CYC cycles after the precharge, and the rest are spaced TRFC_CYC apart.
- R6: The mode load (0000) comes TRFC_CYC cycles after the last refresh, with `sd_ba` = 0. Its address bits are: [2:0] burst length, [3] burst type (0 sequential, 1 interleaved), [6:4] CAS latency, [8:7] operating mode, [9] write-burst mode, and all higher bits 0.
- R7: `init_done` is 0 until TMRD_CYC cycles after the mode load, then 1. While it is 1 the command is NOP and `sd_cke` is 1.
- R8: A synchronous reset at any point, including in the middle of the sequence or after `init_done`, returns the block to the R1 state. The whole sequence then restarts and uses the configuration present at the new mode load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst-length code for the mode word |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS-latency code |
| cfg_op_mode | input | 2 | Operating-mode code |
| cfg_wr_burst | input | 1 | Write-burst mode bit |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address lines |
| init_done | output | 1 | Sequence complete |

## Verification
Faults in the down-counter or its reload values show up as a command that comes one or more cycles early or late. A fault in the loop counter shows up as a missing or extra refresh. Either becomes visible at the pins on the first command after the fault. A wrong state decode gives either a wrong command code or a NOP where a command should be, in the same cycle. A mis-mapped mode field shows up only in the address word of the single mode-load cycle. The bench therefore logs every command at its cycle index, and compares the cycle indices, the codes and the mode word with values computed from the parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_PRECH = 3'd1,
    ST_REFR  = 3'd2,
    ST_LMODE = 3'd3,
    ST_READY = 3'd4
  } init_st_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_INHIBIT = 4'b1111;
  localparam logic [3:0] CMD_NOP     = 4'b0111;
  localparam logic [3:0] CMD_PRECH   = 4'b0010;
  localparam logic [3:0] CMD_REFR    = 4'b0001;
  localparam logic [3:0] CMD_LMODE   = 4'b0000;

  localparam int MODE_FIELD_W = 10;

endpackage

// File: rtl/sdram_wait_cnt.sv
module sdram_wait_cnt #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CW'(RST_VAL);
    else if (load_i)
      cnt_q <= load_val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R4: an expired wait stays expired until the next reload
  a_r4_cnt_holds_zero: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [1:0]        op_mode_i,
  input  logic              wr_burst_i,
  output logic [ADDR_W-1:0] word_o
);
  import sdram_init_pkg::*;

  logic [MODE_FIELD_W-1:0] fields;

  assign fields = {wr_burst_i, op_mode_i, cas_lat_i, burst_type_i, burst_len_i};

  generate
    if (ADDR_W > MODE_FIELD_W) begin : g_pad
      assign word_o = {{(ADDR_W-MODE_FIELD_W){1'b0}}, fields};
    end else begin : g_trunc
      assign word_o = fields[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_d,
  input  logic [3:0]        cmd_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              rdy_d,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rdy_o
);
  import sdram_init_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_o  <= 1'b0;
      cmd_o  <= CMD_INHIBIT;
      ba_o   <= '0;
      addr_o <= '0;
      rdy_o  <= 1'b0;
    end else begin
      cke_o  <= cke_d;
      cmd_o  <= cmd_d;
      ba_o   <= ba_d;
      addr_o <= addr_d;
      rdy_o  <= rdy_d;
    end
  end

  // R1/R2: with clock-enable low the chip is never selected
  a_r1_inhibit_while_cke_low: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> cmd_o[3]);
  // R2: clock-enable never drops once raised
  a_r2_cke_sticky: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o);
  // R3: precharge always addresses all banks
  a_r3_prech_all_banks: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_PRECH) |-> addr_o[10]);
  // R6: mode load uses bank zero and clear reserved bits
  a_r6_lmode_bank_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_LMODE) |-> (ba_o == '0 && addr_o[ADDR_W-1:MODE_FIELD_W] == '0));
  // R7: done is sticky and idle
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    rdy_o |=> rdy_o);
  a_r7_done_nop: assert property (@(posedge clk) disable iff (rst)
    rdy_o |-> (cmd_o == CMD_NOP && cke_o));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int PWRUP_CYC    = 13300,
  parameter int CKE_RISE_CYC = 6650,
  parameter int TRP_CYC      = 3,
  parameter int TRFC_CYC     = 9,
  parameter int TMRD_CYC     = 2,
  parameter int REF_LOOPS    = 2,
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [1:0]        cfg_op_mode,
  input  logic              cfg_wr_burst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  import sdram_init_pkg::*;

  localparam int MAX_A  = (PWRUP_CYC > TRFC_CYC) ? PWRUP_CYC : TRFC_CYC;
  localparam int MAX_B  = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = (MAX_T > 2) ? $clog2(MAX_T) : 1;
  localparam int LOOPS  = (REF_LOOPS < 2) ? 2 : REF_LOOPS;
  localparam int LW     = $clog2(LOOPS);

  localparam logic [CW-1:0] PWRUP_V = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] TRP_V   = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] TRFC_V  = CW'(TRFC_CYC - 1);
  localparam logic [CW-1:0] TMRD_V  = CW'(TMRD_CYC - 1);
  localparam logic [CW-1:0] CKE_AT  = CW'(PWRUP_CYC - 1 - CKE_RISE_CYC);
  localparam logic [LW-1:0] LOOP_LAST = LW'(LOOPS - 1);

  init_st_t        st_q, st_d;
  logic            ent_q;
  logic [LW-1:0]   loop_q;
  logic            load;
  logic [CW-1:0]   load_val;
  logic [CW-1:0]   cnt;
  logic            cnt_zero;
  logic [ADDR_W-1:0] mode_word;

  logic              cke_d, rdy_d;
  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic [3:0]        cmd_q;

  sdram_wait_cnt #(.CW(CW), .RST_VAL(PWRUP_CYC - 1)) u_wait (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .burst_len_i  (cfg_burst_len),
    .burst_type_i (cfg_burst_type),
    .cas_lat_i    (cfg_cas_lat),
    .op_mode_i    (cfg_op_mode),
    .wr_burst_i   (cfg_wr_burst),
    .word_o       (mode_word)
  );

  // next state and wait reload
  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    case (st_q)
      ST_PWRUP: if (cnt_zero) begin
        st_d = ST_PRECH; load = 1'b1; load_val = TRP_V;
      end
      ST_PRECH: if (cnt_zero) begin
        st_d = ST_REFR; load = 1'b1; load_val = TRFC_V;
      end
      ST_REFR: if (cnt_zero) begin
        load = 1'b1;
        if (loop_q == LOOP_LAST) begin
          st_d = ST_LMODE; load_val = TMRD_V;
        end else begin
          st_d = ST_REFR; load_val = TRFC_V;
        end
      end
      ST_LMODE: if (cnt_zero) begin
        st_d = ST_READY; load = 1'b1; load_val = '0;
      end
      default: st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_PWRUP;
      ent_q  <= 1'b1;
      loop_q <= '0;
    end else begin
      st_q  <= st_d;
      ent_q <= load;
      if (st_q == ST_PWRUP)
        loop_q <= '0;
      else if (st_q == ST_REFR && cnt_zero && loop_q != LOOP_LAST)
        loop_q <= loop_q + 1'b1;
    end
  end

  // per-cycle pin values, registered in the drive stage
  always_comb begin
    cke_d  = 1'b1;
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    rdy_d  = 1'b0;
    case (st_q)
      ST_PWRUP: begin
        cke_d = (cnt <= CKE_AT);
        cmd_d = cke_d ? CMD_NOP : CMD_INHIBIT;
      end
      ST_PRECH: if (ent_q) begin
        cmd_d      = CMD_PRECH;
        addr_d[10] = 1'b1;
      end
      ST_REFR: if (ent_q) cmd_d = CMD_REFR;
      ST_LMODE: if (ent_q) begin
        cmd_d  = CMD_LMODE;
        addr_d = mode_word;
      end
      default: rdy_d = 1'b1;
    endcase
  end

  sdram_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .clk    (clk),
    .rst    (rst),
    .cke_d  (cke_d),
    .cmd_d  (cmd_d),
    .ba_d   (ba_d),
    .addr_d (addr_d),
    .rdy_d  (rdy_d),
    .cke_o  (sd_cke),
    .cmd_o  (cmd_q),
    .ba_o   (sd_ba),
    .addr_o (sd_addr),
    .rdy_o  (init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // R5: the refresh loop index never passes the last loop
  a_r5_loop_in_range: assert property (@(posedge clk) disable iff (rst)
    loop_q <= LOOP_LAST);
  // R8: the sequencer never leaves done without a reset
  a_r8_done_until_reset: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_READY) |=> (st_q == ST_READY));

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  localparam int P    = 40;
  localparam int RISE = 15;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TMRD = 2;
  localparam int L    = 3;
  localparam int NEV  = L + 2;
  localparam int CAPN = 80;
  localparam int T_RDY = P + TRP + L*TRFC + TMRD;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  // expected command table: code and cycle index after reset release
  localparam logic [3:0] EV_CMD [0:NEV-1] = '{C_PRE, C_REF, C_REF, C_REF, C_LMR};
  localparam int         EV_AT  [0:NEV-1] = '{P, P+TRP, P+TRP+TRFC,
                                              P+TRP+2*TRFC, P+TRP+3*TRFC};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_bl = '0;
  logic       cfg_bt = 1'b0;
  logic [2:0] cfg_cl = '0;
  logic [1:0] cfg_op = '0;
  logic       cfg_wb = 1'b0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;

  int nvec = 0;
  int nfail = 0;

  logic        cap_cke [0:CAPN-1];
  logic [3:0]  cap_cmd [0:CAPN-1];
  logic [11:0] cap_addr[0:CAPN-1];
  logic [1:0]  cap_ba  [0:CAPN-1];
  logic        cap_rdy [0:CAPN-1];

  always #5 clk = ~clk;

  sdram_init_seq #(
    .PWRUP_CYC(P), .CKE_RISE_CYC(RISE), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
    .TMRD_CYC(TMRD), .REF_LOOPS(L), .ADDR_W(12), .BA_W(2)
  ) dut (
    .clk(clk), .rst(rst),
    .cfg_burst_len(cfg_bl), .cfg_burst_type(cfg_bt), .cfg_cas_lat(cfg_cl),
    .cfg_op_mode(cfg_op), .cfg_wr_burst(cfg_wb),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_reset_pins(input string req);
    chk(sd_cke === 1'b0, req, "cke in reset", int'(sd_cke), 0);
    chk(sd_cs_n === 1'b1, req, "cs_n in reset", int'(sd_cs_n), 1);
    chk(init_done === 1'b0, req, "done in reset", int'(init_done), 0);
  endtask

  task automatic capture(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      cap_cke[j]  = sd_cke;
      cap_cmd[j]  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      cap_addr[j] = sd_addr;
      cap_ba[j]   = sd_ba;
      cap_rdy[j]  = init_done;
    end
  endtask

  task automatic analyze(input logic [11:0] exp_word);
    int bad;
    int nev;
    int ev_idx [0:15];
    bad = 0;
    for (int j = 0; j < RISE; j++)
      if (cap_cke[j] !== 1'b0 || cap_cmd[j][3] !== 1'b1) bad++;
    chk(bad == 0, "R2", "inhibit cycles with cke low", bad, 0);
    chk(cap_cke[RISE] === 1'b1, "R2", "cke rise cycle", int'(cap_cke[RISE]), 1);
    bad = 0;
    for (int j = RISE; j < P; j++)
      if (cap_cke[j] !== 1'b1 || cap_cmd[j] !== C_NOP) bad++;
    chk(bad == 0, "R2", "nop cycles with cke high", bad, 0);
    bad = 0;
    for (int j = P; j < CAPN; j++)
      if (cap_cke[j] !== 1'b1) bad++;
    chk(bad == 0, "R2", "cke dropped after delay", bad, 0);
    nev = 0;
    for (int j = P; j < CAPN; j++)
      if (cap_cmd[j] !== C_NOP) begin
        if (nev < 16) ev_idx[nev] = j;
        nev++;
      end
    chk(nev == NEV, "R4", "non-NOP command count", nev, NEV);
    // table walk: code and cycle of each expected command
    for (int k = 0; k < NEV; k++) begin
      string rq;
      rq = (k == 0) ? "R3" : ((k == NEV-1) ? "R6" : "R5");
      if (k < nev && k < 16) begin
        chk(cap_cmd[ev_idx[k]] === EV_CMD[k], rq, "command code",
            int'(cap_cmd[ev_idx[k]]), int'(EV_CMD[k]));
        chk(ev_idx[k] == EV_AT[k], "R4", "command cycle", ev_idx[k], EV_AT[k]);
      end else begin
        chk(1'b0, rq, "missing command", k, NEV);
      end
    end
    chk(cap_addr[EV_AT[0]][10] === 1'b1, "R3", "precharge A10",
        int'(cap_addr[EV_AT[0]][10]), 1);
    chk(cap_addr[EV_AT[NEV-1]] === exp_word, "R6", "mode word",
        int'(cap_addr[EV_AT[NEV-1]]), int'(exp_word));
    chk(cap_ba[EV_AT[NEV-1]] === 2'b00, "R6", "mode bank address",
        int'(cap_ba[EV_AT[NEV-1]]), 0);
    bad = 0;
    for (int j = 0; j < T_RDY; j++)
      if (cap_rdy[j] !== 1'b0) bad++;
    chk(bad == 0, "R7", "early done cycles", bad, 0);
    bad = 0;
    for (int j = T_RDY; j < CAPN; j++)
      if (cap_rdy[j] !== 1'b1 || cap_cmd[j] !== C_NOP) bad++;
    chk(bad == 0, "R7", "done with NOP from its cycle", bad, 0);
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    // run 1: sequential? no, interleaved burst, fields 3/1/2/0/1 -> 0x22B
    cfg_bl = 3'b011; cfg_bt = 1'b1; cfg_cl = 3'b010; cfg_op = 2'b00; cfg_wb = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_pins("R1");
    rst = 1'b0;
    capture(CAPN);
    chk(cap_cke[0] === 1'b0 && cap_cmd[0][3] === 1'b1, "R1", "first cycle after release",
        int'({cap_cke[0], cap_cmd[0]}), 15);
    analyze(12'h22B);

    // R8: reset after done, new fields 7/0/3/3/0 -> 0x1B7
    cfg_bl = 3'b111; cfg_bt = 1'b0; cfg_cl = 3'b011; cfg_op = 2'b11; cfg_wb = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check_reset_pins("R8");
    @(negedge clk);
    rst = 1'b0;
    // R8: reset in the middle of the refresh loop
    capture(P + TRP + TRFC + 2);
    chk(cap_cmd[P] === C_PRE, "R8", "restart precharge", int'(cap_cmd[P]), int'(C_PRE));
    rst = 1'b1;
    @(negedge clk);
    check_reset_pins("R8");
    @(negedge clk);
    rst = 1'b0;
    capture(CAPN);
    analyze(12'h1B7);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule